// File: doc/BRIEF.md
# T1 Yellow Alarm Inserter

This block sits in the transmit path of a T1 line, after framing and before line coding. It receives a stream that is already framed, one bit per clock. Alongside each bit come strobes that mark the start of a superframe, the framing-bit slot, and the data-link slot. Two index inputs give the frame number within the superframe and the bit position within a channel. When the remote (yellow) alarm is requested, the block overwrites the bits that carry that alarm and passes every other bit through unchanged. Output latency is one clock.

Two inputs choose the encoding. The first selects the 12-frame superframe or the 24-frame extended superframe. The second picks one of the two encodings that the selected framing mode offers:

- In 12-frame mode, the alarm either clears the second bit of every channel or sets the framing bit of frame 12.
- In extended mode, the alarm either sends a repeating 16-bit pattern in the data link or clears the second bit of every channel.

All three control inputs (alarm enable, framing mode, encoding select) are sampled only on the clock that carries the superframe-start strobe. A change made partway through a superframe therefore does not alter the rest of that superframe.

Top module: `t1_yellow_inserter`

## Requirements
- R1: While rst_n is low, dout is 0, the alarm is held inactive and the pattern phase is cleared to zero.
- R2: Every bit not named in R3 to R6 leaves dout exactly one clock after it enters on din, with its value unchanged. This covers all bits while the alarm is inactive.
- R3: In 12-frame mode (esf_mode=0) with yel_fmt=0 and the alarm active, every bit with fbit_stb=0 and bit_idx=1 is sent as 0. bit_idx=0 is the first bit of a channel, so bit_idx=1 is its second bit.
- R4: In 12-frame mode with yel_fmt=1 and the alarm active, the framing bit of frame 12 is sent as 1. That bit is the one with fbit_stb=1 and frame_idx=11, where frame_idx counts from 0. All channel bits pass unchanged.
- R5: In extended mode (esf_mode=1) with yel_fmt=0 and the alarm active, data-link slots (dl_stb=1) carry the 16-bit pattern 16'hFF00, most significant bit first. That is eight ones followed by eight zeros, repeated. The pattern position advances only on data-link slots. It restarts at the first bit whenever this encoding becomes active.
- R6: In extended mode with yel_fmt=1 and the alarm active, every bit with fbit_stb=0 and bit_idx=1 is sent as 0. Data-link and other framing slots pass unchanged.
- R7: alarm_en, esf_mode and yel_fmt are sampled only on a clock where sf_start=1. Changes at any other time do not affect dout until the next superframe start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_en | input | 1 | Request to send the yellow alarm |
| esf_mode | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| yel_fmt | input | 1 | Selects between the two alarm encodings of the mode |
| sf_start | input | 1 | Marks the first bit of a superframe |
| fbit_stb | input | 1 | Marks a framing-bit slot |
| dl_stb | input | 1 | Marks a data-link slot (extended mode) |
| frame_idx | input | FRM_W | Frame number within the superframe, from 0 |
| bit_idx | input | 3 | Bit position in the channel, 0 = first bit |
| din | input | 1 | Incoming framed bit |
| dout | output | 1 | Outgoing bit, one clock later |

## Verification
Every result of this block appears on dout one clock after the bit it belongs to. This holds whether the bit passes through, is cleared, is forced high, or is replaced by a pattern bit. The bench drives each slot on a falling edge and records that slot's expected value in its own model. It compares dout on the next falling edge, after the single register has loaded.

Configuration changes made partway through a superframe must not take effect before the next superframe-start slot. The model applies them from that slot onward, and those checks are tagged to the sampling requirement.

// File: rtl/t1_yellow_inserter.sv
module t1_yellow_inserter #(
  parameter int             PAT_W    = 16,
  parameter logic [PAT_W-1:0] PAT    = 16'hFF00,
  parameter int             FRM_W    = 5,
  parameter int             FS_FRAME = 11,
  parameter int             B2_IDX   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alarm_en,
  input  logic             esf_mode,
  input  logic             yel_fmt,
  input  logic             sf_start,
  input  logic             fbit_stb,
  input  logic             dl_stb,
  input  logic [FRM_W-1:0] frame_idx,
  input  logic [2:0]       bit_idx,
  input  logic             din,
  output logic             dout
);
  localparam int PH_W = $clog2(PAT_W);
  localparam logic [PH_W-1:0] PH_MAX = PH_W'(PAT_W - 1);

  logic en_q, esf_q, fmt_q;
  logic [PH_W-1:0] phase;

  wire en_c  = sf_start ? alarm_en : en_q;
  wire esf_c = sf_start ? esf_mode : esf_q;
  wire fmt_c = sf_start ? yel_fmt  : fmt_q;

  wire b2_slot = !fbit_stb && (bit_idx == 3'(B2_IDX));
  wire dl_mode = en_c && esf_c && !fmt_c;
  wire do_b2   = en_c && b2_slot && (esf_c ? fmt_c : !fmt_c);
  wire do_fs   = en_c && !esf_c && fmt_c && fbit_stb && (frame_idx == FRM_W'(FS_FRAME));
  wire do_dl   = dl_mode && dl_stb;
  wire pat_bit = PAT[PH_MAX - phase];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      esf_q <= 1'b0;
      fmt_q <= 1'b0;
    end else if (sf_start) begin
      en_q  <= alarm_en;
      esf_q <= esf_mode;
      fmt_q <= yel_fmt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dl_mode)
      phase <= '0;
    else if (dl_stb)
      phase <= (phase == PH_MAX) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dout <= 1'b0;
    else if (do_dl) dout <= pat_bit;
    else if (do_fs) dout <= 1'b1;
    else if (do_b2) dout <= 1'b0;
    else            dout <= din;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (dout == 1'b0) && !en_q && (phase == '0));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_dl || do_fs || do_b2) |=> dout == $past(din));

  // R3
  b2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_b2 |=> !dout);

  // R4
  fs12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_fs |=> dout);

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_mode && !dl_stb) |=> $stable(phase));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_start |=> $stable({en_q, esf_q, fmt_q}));
endmodule

// File: tb/tb_t1_yellow_inserter.sv
module tb_t1_yellow_inserter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic alarm_en = 0, esf_mode = 0, yel_fmt = 0;
  logic sf_start = 0, fbit_stb = 0, dl_stb = 0, din = 0;
  logic [4:0] frame_idx = '0;
  logic [2:0] bit_idx = '0;
  logic dout;

  always #2.5 clk = ~clk;

  t1_yellow_inserter dut (
    .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .esf_mode(esf_mode),
    .yel_fmt(yel_fmt), .sf_start(sf_start), .fbit_stb(fbit_stb), .dl_stb(dl_stb),
    .frame_idx(frame_idx), .bit_idx(bit_idx), .din(din), .dout(dout)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int bp = 0, fr = 0, ph = 0;
  bit l_en = 0, l_esf = 0, l_fmt = 0;
  bit have_exp = 0;
  logic exp_bit;
  string exp_tag;
  logic [15:0] pat = 16'hFF00;

  task automatic chk(input logic act, input logic ex, input string tag);
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s: dout=%b expected=%b at %0t", tag, act, ex, $time);
    end
  endtask

  task automatic step();
    bit fb, dl, sf;
    int bi;
    @(negedge clk);
    if (have_exp) chk(dout, exp_bit, exp_tag);
    sf = (fr == 0 && bp == 0);
    if (sf) begin
      l_en = alarm_en; l_esf = esf_mode; l_fmt = yel_fmt;
    end
    fb = (bp == 0);
    dl = l_esf && fb && (fr % 2 == 0);
    bi = fb ? 0 : (bp - 1) % 8;
    sf_start = sf; fbit_stb = fb; dl_stb = dl;
    frame_idx = 5'(fr); bit_idx = 3'(bi);
    din = 1'($urandom % 2);
    exp_bit = din;
    exp_tag = "R2";
    if (l_en && l_esf && !l_fmt) begin
      if (dl) begin
        exp_bit = pat[15 - ph]; exp_tag = "R5";
        ph = (ph + 1) % 16;
      end
    end else begin
      ph = 0;
      if (l_en && (l_esf == l_fmt) && !fb && bi == 1) begin
        exp_bit = 1'b0; exp_tag = l_esf ? "R6" : "R3";
      end else if (l_en && !l_esf && l_fmt && fb && fr == 11) begin
        exp_bit = 1'b1; exp_tag = "R4";
      end
    end
    if (!sf && (alarm_en != l_en || esf_mode != l_esf || yel_fmt != l_fmt))
      exp_tag = {exp_tag, "/R7"};
    have_exp = 1;
    bp++;
    if (bp == 193) begin
      bp = 0;
      fr++;
      if (fr == (l_esf ? 24 : 12)) fr = 0;
    end
  endtask

  task automatic run(input int n, input bit en, input bit esf, input bit fmt);
    alarm_en = en; esf_mode = esf; yel_fmt = fmt;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      din = 1'b1;
      if (i > 0) chk(dout, 1'b0, "R1");
    end
    rst_n = 1'b1;
    run(3000, 0, 0, 0);
    run(5000, 1, 0, 0);
    run(4800, 1, 0, 1);
    run(2500, 0, 0, 1);
    run(12000, 1, 1, 0);
    run(9500, 1, 1, 1);
    run(6000, 1, 1, 0);
    run(5200, 0, 1, 0);
    run(7000, 1, 0, 1);
    run(3000, 0, 0, 0);
    @(negedge clk);
    chk(dout, exp_bit, exp_tag);
    finish_up();
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end
endmodule